// File: doc/BRIEF.md
# Break-Aware Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial line. A clock enable pulsing sixteen times per bit period paces it. The line is first passed through a synchronizer. A falling level is then confirmed as a start bit at mid-bit, and eight or nine data bits are collected least significant bit first. One stop bit is checked last. Each finished character comes out as a nine-bit word tagged with a framing-error bit and a parity-error bit. A plain status pin tells whether the receiver is between characters.

A line held low for longer than a whole character counts as a break. It completes as an ordinary frame whose stop bit was found low, so it yields a single all-zero word with the framing error set. The receiver then stays disarmed while the line remains low, and re-arms only after the line has stayed high for one full bit time. While it waits, the status pin already reads idle.

Words leave on a valid/ready interface. The serial line cannot be paused, so back-pressure never stalls reception. A word that is still waiting stays valid and unchanged until it is taken. If the next character completes first, it replaces the waiting word.

Top module: `uart_break_rx`

## Requirements
- R1: The line passes through a two-flop synchronizer. A low level seen on a sample tick while armed starts a character. That start is confirmed only if the line is still low on the eighth tick that follows. If it is high there, the receiver returns to waiting with no word and no flag.
- R2: `cfg_nine_bits` = 1 selects nine data bits and 0 selects eight. Each data bit is sampled sixteen ticks after the previous sample, and the first bit received lands in `word_data[0]`. In eight-bit mode `word_data[8]` is 0.
- R3: A stop bit sampled high delivers the word with `frame_err` = 0.
- R4: A stop bit sampled low still delivers the word, with `frame_err` = 1.
- R5: A break (line low for longer than a character) yields exactly one word, with `word_data` = 0 and `frame_err` = 1. No further word follows while the line stays low.
- R6: After a framing error, a new start is accepted only once the line has been high for 16 consecutive ticks. A shorter high followed by low produces no word.
- R7: `rx_idle` is 0 from start detection until the stop bit is sampled. It is 1 otherwise, including while the receiver waits out a break.
- R8: When `cfg_nine_bits` = 1 and `cfg_parity_en` = 1, `parity_err` is the XOR of all nine received bits, so an odd count of ones is an error under even parity. Otherwise `parity_err` = 0.
- R9: `word_valid` stays high with word and flags stable until `word_ready`, and it drops in the cycle after the handshake. A newly completed character replaces a word that has not been accepted.
- R10: After reset, `word_valid` = 0, `rx_idle` = 1 and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_tick | input | 1 | Enable pulse, 16 per bit period |
| cfg_nine_bits | input | 1 | 1: nine data bits, 0: eight |
| cfg_parity_en | input | 1 | Treat ninth bit as even parity |
| rx_line | input | 1 | Asynchronous serial line, idle high |
| word_ready | input | 1 | Consumer accepts the word |
| word_valid | output | 1 | Word available |
| word_data | output | 9 | Received data, first bit in bit 0 |
| frame_err | output | 1 | Stop bit was low for this word |
| parity_err | output | 1 | Even-parity failure for this word |
| rx_idle | output | 1 | Receiver between characters |

## Verification
A table of characters covers both word lengths, parity enabled and disabled with odd and even counts of ones, and stop bits high and low. Together these separate the data path, the parity logic and the framing check. Three directed patterns cover the timing edge cases. A short low glitch shows that mid-bit confirmation is used. A long break shows that one zero word appears, that the receiver does not retrigger, and that the status pin reads idle during the wait. A high pulse shorter than a bit time shows that the re-arm needs a full stop level. A held, unaccepted word checks that back-pressure keeps the word stable and that a later character overwrites it.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int WORD_BITS = 9;

  typedef enum logic [2:0] {
    RX_ARMED,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_RECOVER
  } rx_state_e;

  typedef struct packed {
    logic [WORD_BITS-1:0] data;
    logic                 ferr;
    logic                 perr;
  } rx_word_t;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick_i,
  input  logic     line_i,
  input  logic     nine_i,
  input  logic     par_en_i,
  output logic     done_o,
  output rx_word_t word_o,
  output logic     idle_o
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam int BW = $clog2(WORD_BITS);
  localparam logic [CW-1:0] MID  = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

  rx_state_e            state;
  logic [CW-1:0]        tcnt;
  logic [BW-1:0]        bidx;
  logic [WORD_BITS-1:0] shreg;
  logic [BW-1:0]        last_bit;

  assign last_bit = nine_i ? BW'(WORD_BITS - 1) : BW'(WORD_BITS - 2);
  assign idle_o   = (state == RX_ARMED) || (state == RX_RECOVER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RX_ARMED;
      tcnt   <= '0;
      bidx   <= '0;
      shreg  <= '0;
      done_o <= 1'b0;
      word_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        unique case (state)
          RX_ARMED: begin
            if (!line_i) begin
              state <= RX_START;
              tcnt  <= '0;
            end
          end
          RX_START: begin
            if (tcnt == MID) begin
              tcnt  <= '0;
              bidx  <= '0;
              shreg <= '0;
              state <= line_i ? RX_ARMED : RX_DATA;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (tcnt == LAST) begin
              tcnt        <= '0;
              shreg[bidx] <= line_i;
              if (bidx == last_bit) state <= RX_STOP;
              else                  bidx  <= bidx + 1'b1;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (tcnt == LAST) begin
              tcnt        <= '0;
              done_o      <= 1'b1;
              word_o.data <= shreg;
              word_o.ferr <= !line_i;
              word_o.perr <= nine_i && par_en_i && (^shreg);
              state       <= line_i ? RX_ARMED : RX_RECOVER;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          RX_RECOVER: begin
            if (!line_i)           tcnt  <= '0;
            else if (tcnt == LAST) state <= RX_ARMED;
            else                   tcnt  <= tcnt + 1'b1;
          end
          default: state <= RX_ARMED;
        endcase
      end
    end
  end

  AST_START_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle_o) |-> !$past(line_i)); // R1
  AST_EIGHT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !nine_i) |-> !word_o.data[WORD_BITS-1]); // R2
  AST_RECOVER_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_RECOVER) |=> (state == RX_RECOVER || state == RX_ARMED)); // R6
  AST_RECOVER_LOW_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_RECOVER && tick_i && !line_i) |=> (state == RX_RECOVER)); // R6
  AST_PERR_NEEDS_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && word_o.perr) |-> (nine_i && par_en_i)); // R8
endmodule

// File: rtl/rx_word_hold.sv
module rx_word_hold
  import serial_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_i,
  input  rx_word_t word_i,
  input  logic     ready_i,
  output logic     valid_o,
  output rx_word_t word_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      word_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      word_o  <= word_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  AST_VALID_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i && !load_i) |=> (valid_o && $stable(word_o))); // R9
  AST_LOAD_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (valid_o && word_o == $past(word_i))); // R9
endmodule

// File: rtl/uart_break_rx.sv
module uart_break_rx
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_tick,
  input  logic                 cfg_nine_bits,
  input  logic                 cfg_parity_en,
  input  logic                 rx_line,
  input  logic                 word_ready,
  output logic                 word_valid,
  output logic [WORD_BITS-1:0] word_data,
  output logic                 frame_err,
  output logic                 parity_err,
  output logic                 rx_idle
);
  logic     line_s;
  logic     done;
  rx_word_t eng_word;
  rx_word_t out_word;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx_line), .q_o(line_s)
  );

  rx_frame_engine #(.OVERSAMPLE(OVERSAMPLE)) u_engine (
    .clk(clk), .rst_n(rst_n), .tick_i(sample_tick), .line_i(line_s),
    .nine_i(cfg_nine_bits), .par_en_i(cfg_parity_en),
    .done_o(done), .word_o(eng_word), .idle_o(rx_idle)
  );

  rx_word_hold u_hold (
    .clk(clk), .rst_n(rst_n), .load_i(done), .word_i(eng_word),
    .ready_i(word_ready), .valid_o(word_valid), .word_o(out_word)
  );

  assign word_data  = out_word.data;
  assign frame_err  = out_word.ferr;
  assign parity_err = out_word.perr;

  AST_FERR_ONLY_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> word_valid); // R4
endmodule

// File: tb/test_uart_break_rx.sv
module test_uart_break_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       nine = 1'b0;
  logic       par = 1'b0;
  logic       rxd = 1'b1;
  logic       rdy = 1'b1;
  logic       word_valid;
  logic [8:0] word_data;
  logic       frame_err;
  logic       parity_err;
  logic       rx_idle;

  int tests = 0;
  int fails = 0;
  int nwords = 0;
  logic [8:0] cap_d = '0;
  logic       cap_f = 1'b0;
  logic       cap_p = 1'b0;

  localparam int BIT_CYC = 64;

  // {nine, par, stop, data[8:0], expected word[8:0], exp ferr, exp perr}
  localparam logic [22:0] VEC [7] = '{
    {1'b0, 1'b0, 1'b1, 9'h0A5, 9'h0A5, 1'b0, 1'b0},
    {1'b0, 1'b0, 1'b1, 9'h1FF, 9'h0FF, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b1, 9'h155, 9'h155, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b1, 9'h103, 9'h103, 1'b0, 1'b1},
    {1'b1, 1'b1, 1'b1, 9'h180, 9'h180, 1'b0, 1'b0},
    {1'b0, 1'b0, 1'b0, 9'h03C, 9'h03C, 1'b1, 1'b0},
    {1'b1, 1'b0, 1'b1, 9'h101, 9'h101, 1'b0, 1'b0}
  };

  uart_break_rx i_uart_break_rx (
    .clk(clk), .rst_n(rst_n), .sample_tick(tick), .cfg_nine_bits(nine),
    .cfg_parity_en(par), .rx_line(rxd), .word_ready(rdy),
    .word_valid(word_valid), .word_data(word_data), .frame_err(frame_err),
    .parity_err(parity_err), .rx_idle(rx_idle)
  );

  always #4 clk = ~clk;

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      tick = (c == 3);
      c = (c + 1) % 4;
    end
  end

  always @(posedge clk) begin
    if (rst_n && word_valid && rdy) begin
      cap_d  <= word_data;
      cap_f  <= frame_err;
      cap_p  <= parity_err;
      nwords <= nwords + 1;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic n9, input logic [8:0] d, input logic stopv);
    rxd = 1'b0;
    hold(BIT_CYC);
    for (int b = 0; b < (n9 ? 9 : 8); b++) begin
      rxd = d[b];
      hold(BIT_CYC);
    end
    rxd = stopv;
    hold(BIT_CYC);
    rxd = 1'b1;
    hold(2 * BIT_CYC);
  endtask

  initial begin
    hold(200000);
    fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n0;
    hold(5);
    rst_n = 1'b1;
    hold(2);
    // R10: reset state
    chk(word_valid == 1'b0, "R10 valid after reset", word_valid, 0);
    chk(rx_idle == 1'b1, "R10 idle after reset", rx_idle, 1);
    chk(frame_err == 1'b0 && parity_err == 1'b0, "R10 flags after reset",
        {frame_err, parity_err}, 0);
    hold(BIT_CYC);

    // R2 R3 R4 R8: table of characters
    for (int i = 0; i < 7; i++) begin
      nine = VEC[i][22];
      par  = VEC[i][21];
      n0   = nwords;
      send_frame(VEC[i][22], VEC[i][19:11], VEC[i][20]);
      chk(nwords == n0 + 1, $sformatf("R3 one word vec %0d", i), nwords - n0, 1);
      chk(cap_d == VEC[i][10:2], $sformatf("R2 data vec %0d", i), cap_d, VEC[i][10:2]);
      chk(cap_f == VEC[i][1], $sformatf("R4 frame_err vec %0d", i), cap_f, VEC[i][1]);
      chk(cap_p == VEC[i][0], $sformatf("R8 parity_err vec %0d", i), cap_p, VEC[i][0]);
    end
    nine = 1'b0;
    par  = 1'b0;

    // R7: busy during a character
    n0 = nwords;
    fork
      send_frame(1'b0, 9'h066, 1'b1);
      begin
        hold(3 * BIT_CYC);
        chk(rx_idle == 1'b0, "R7 idle low mid-character", rx_idle, 0);
      end
    join
    chk(cap_d == 9'h066 && nwords == n0 + 1, "R7 word after busy check", cap_d, 9'h066);

    // R1: glitch shorter than half a bit
    n0 = nwords;
    rxd = 1'b0;
    hold(12);
    rxd = 1'b1;
    hold(12 * BIT_CYC);
    chk(nwords == n0, "R1 glitch gives no word", nwords - n0, 0);
    chk(rx_idle == 1'b1, "R1 idle after glitch", rx_idle, 1);

    // R5 R7: long break
    n0 = nwords;
    rxd = 1'b0;
    hold(20 * BIT_CYC);
    chk(nwords == n0 + 1, "R5 break gives one word", nwords - n0, 1);
    chk(cap_d == 9'h000, "R5 break data zero", cap_d, 0);
    chk(cap_f == 1'b1, "R5 break frame_err", cap_f, 1);
    chk(rx_idle == 1'b1, "R7 idle high while break continues", rx_idle, 1);

    // R6: high shorter than a bit time does not re-arm
    rxd = 1'b1;
    hold(32);
    rxd = 1'b0;
    hold(12 * BIT_CYC);
    chk(nwords == n0 + 1, "R6 short high does not re-arm", nwords - n0, 1);
    rxd = 1'b1;
    hold(2 * BIT_CYC);
    send_frame(1'b0, 9'h05A, 1'b1);
    chk(nwords == n0 + 2 && cap_d == 9'h05A, "R6 re-armed after full stop level",
        cap_d, 9'h05A);
    chk(cap_f == 1'b0, "R6 clean frame after recovery", cap_f, 0);

    // R9: back-pressure and overwrite
    rdy = 1'b0;
    n0 = nwords;
    send_frame(1'b0, 9'h0C3, 1'b1);
    chk(word_valid == 1'b1 && word_data == 9'h0C3, "R9 held word", word_data, 9'h0C3);
    hold(100);
    chk(word_valid == 1'b1 && word_data == 9'h0C3, "R9 word stable under stall",
        word_data, 9'h0C3);
    send_frame(1'b0, 9'h03E, 1'b1);
    chk(word_data == 9'h03E, "R9 newer word replaces waiting one", word_data, 9'h03E);
    rdy = 1'b1;
    hold(1);
    chk(word_valid == 1'b0, "R9 valid drops after handshake", word_valid, 0);
    chk(nwords == n0 + 1 && cap_d == 9'h03E, "R9 single accepted word", cap_d, 9'h03E);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule